// File: doc/BRIEF.md
# Transmitter Audio Mode Decoder

This block holds the transmitter's audio operating mode and turns it into the status and control lines used around the audio path. A two-bit mode code arrives on a small parallel bus. It is taken into a register only on a cycle where the capture strobe is high. The register then drives every output, so the outputs change in step and do not follow glitches on the code lines.

The registered code is kept in true and complemented form. A four-way match turns it into one of stereo, mono left, mono right or mono sum (L+R). From that mode the block drives a group of active-low status lines: an internal stereo status, a stereo lamp drive, a remote stereo status, a remote mono status and a single-channel flag for the exciter. It also drives an active-high stereo request, copied onto each equalization selection lane. A synchronous reset puts the block in stereo mode.

Top module: `audio_mode_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block loads stereo mode (code 2'b00), so the outputs after that edge show the stereo state.
- R2: When `cap_stb` is high at a rising edge (and `rst` is low), the value on `mode_code` at that edge sets the outputs seen just after that same edge.
- R3: A change on `mode_code` while `cap_stb` is low has no effect on any output.
- R4: Code 2'b00 (stereo) drives `stereo_int_n`, `stereo_lamp_n` and `stereo_rmt_n` low, `mono_rmt_n` and `single_ch_n` high, and every bit of `eq_stereo_req` high.
- R5: Code 2'b01 (mono left) drives `single_ch_n` and `mono_rmt_n` low, the three stereo status lines high, and `eq_stereo_req` all low.
- R6: Code 2'b10 (mono right) gives the same output pattern as mono left.
- R7: Code 2'b11 (mono sum) drives `mono_rmt_n` low while `single_ch_n` stays high, with the stereo lines high and `eq_stereo_req` all low.
- R8: Exactly one of `stereo_rmt_n` and `mono_rmt_n` is low at any time after reset.
- R9: `stereo_int_n`, `stereo_lamp_n` and `stereo_rmt_n` are always equal, and each bit of `eq_stereo_req` is their inverse.
- R10: Reset wins over a capture strobe that is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to stereo mode |
| cap_stb | input | 1 | Capture strobe for the mode code |
| mode_code | input | 2 | Mode code: 00 stereo, 01 mono left, 10 mono right, 11 mono sum |
| stereo_int_n | output | 1 | Internal stereo status, low in stereo |
| stereo_lamp_n | output | 1 | Stereo lamp drive, low in stereo |
| stereo_rmt_n | output | 1 | Remote stereo status, low in stereo |
| mono_rmt_n | output | 1 | Remote mono status, low in any mono mode |
| single_ch_n | output | 1 | Single-channel flag, low in mono left and mono right |
| eq_stereo_req | output | EQ_LANES | Stereo request to each equalization lane, high in stereo |

## Verification
Each of the four codes is captured with a strobe, both in order and out of order, so that every pattern is reached from more than one earlier mode. Code changes made with the strobe held low show whether the register follows the bus without a strobe. Mono left and mono right give the same output pattern and must both differ from mono sum, so a swapped bit in the decode shows up as a wrong single-channel flag. A reset that arrives together with a strobe and a mono code shows which of the two takes priority.

// File: rtl/amd_pkg.sv
package amd_pkg;

    localparam int MODE_W = 2;
    localparam int MODE_COUNT = 1 << MODE_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_STEREO  = 2'b00,
        MODE_MONO_L  = 2'b01,
        MODE_MONO_R  = 2'b10,
        MODE_MONO_LR = 2'b11
    } amd_mode_e;

    typedef struct packed {
        logic stereo_int_n;
        logic stereo_lamp_n;
        logic stereo_rmt_n;
        logic mono_rmt_n;
        logic single_ch_n;
        logic stereo_req;
    } amd_status_t;

endpackage

// File: rtl/amd_code_latch.sv
module amd_code_latch
    import amd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_stb,
    input  logic [MODE_W-1:0] code_in,
    output logic [MODE_W-1:0] code_t,
    output logic [MODE_W-1:0] code_c
);

    typedef struct packed {
        logic [MODE_W-1:0] code;
    } latch_state_t;

    latch_state_t state_d;
    latch_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.code = MODE_STEREO;
        end else if (cap_stb) begin
            state_d.code = code_in;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign code_t = state_q.code;
    assign code_c = ~state_q.code;

endmodule

// File: rtl/amd_mode_decode.sv
module amd_mode_decode
    import amd_pkg::*;
(
    input  logic [MODE_W-1:0] code_t,
    input  logic [MODE_W-1:0] code_c,
    output amd_status_t       status
);

    logic [MODE_COUNT-1:0] hit;

    // Each mode matches where the true rail is set for its one bits and the
    // complement rail is set for its zero bits.
    for (genvar m = 0; m < MODE_COUNT; m++) begin : g_match
        localparam logic [MODE_W-1:0] KEY = MODE_W'(m);
        assign hit[m] = &((code_t & KEY) | (code_c & ~KEY));
    end

    logic is_stereo;
    logic is_one_side;
    logic is_mono;

    always_comb begin
        is_stereo   = hit[MODE_STEREO];
        is_one_side = hit[MODE_MONO_L] | hit[MODE_MONO_R];
        is_mono     = is_one_side | hit[MODE_MONO_LR];

        status.stereo_int_n  = ~is_stereo;
        status.stereo_lamp_n = ~is_stereo;
        status.stereo_rmt_n  = ~is_stereo;
        status.mono_rmt_n    = ~is_mono;
        status.single_ch_n   = ~is_one_side;
        status.stereo_req    = is_stereo;
    end

endmodule

// File: rtl/audio_mode_decoder.sv
module audio_mode_decoder
    import amd_pkg::*;
#(
    parameter int EQ_LANES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_stb,
    input  logic [1:0]          mode_code,
    output logic                stereo_int_n,
    output logic                stereo_lamp_n,
    output logic                stereo_rmt_n,
    output logic                mono_rmt_n,
    output logic                single_ch_n,
    output logic [EQ_LANES-1:0] eq_stereo_req
);

    logic [MODE_W-1:0] code_t;
    logic [MODE_W-1:0] code_c;
    amd_status_t       status;

    amd_code_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .cap_stb (cap_stb),
        .code_in (mode_code),
        .code_t  (code_t),
        .code_c  (code_c)
    );

    amd_mode_decode u_decode (
        .code_t (code_t),
        .code_c (code_c),
        .status (status)
    );

    assign stereo_int_n  = status.stereo_int_n;
    assign stereo_lamp_n = status.stereo_lamp_n;
    assign stereo_rmt_n  = status.stereo_rmt_n;
    assign mono_rmt_n    = status.mono_rmt_n;
    assign single_ch_n   = status.single_ch_n;

    for (genvar i = 0; i < EQ_LANES; i++) begin : g_eq
        assign eq_stereo_req[i] = status.stereo_req;
    end

endmodule

// File: rtl/amd_checker.sv
module amd_checker #(
    parameter int EQ_LANES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                cap_stb,
    input logic [1:0]          mode_code,
    input logic                stereo_int_n,
    input logic                stereo_lamp_n,
    input logic                stereo_rmt_n,
    input logic                mono_rmt_n,
    input logic                single_ch_n,
    input logic [EQ_LANES-1:0] eq_stereo_req
);

    logic [4+EQ_LANES:0] outs;
    assign outs = {stereo_int_n, stereo_lamp_n, stereo_rmt_n,
                   mono_rmt_n, single_ch_n, eq_stereo_req};

    // R1 R10
    reset_stereo_chk: assert property (@(posedge clk)
        rst |=> (!stereo_rmt_n && mono_rmt_n && single_ch_n));

    // R2
    capture_decode_chk: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> (single_ch_n == !($past(mode_code) == 2'b01 || $past(mode_code) == 2'b10))
                 && (stereo_rmt_n == ($past(mode_code) != 2'b00)));

    // R3
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(outs));

    // R8
    remote_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        stereo_rmt_n != mono_rmt_n);

    // R9
    stereo_group_chk: assert property (@(posedge clk) disable iff (rst)
        (stereo_int_n == stereo_lamp_n) && (stereo_lamp_n == stereo_rmt_n)
        && (eq_stereo_req == {EQ_LANES{!stereo_int_n}}));

    // R5 R6
    single_implies_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !single_ch_n |-> !mono_rmt_n);

endmodule

bind audio_mode_decoder amd_checker #(.EQ_LANES(EQ_LANES)) u_amd_checker (
    .clk           (clk),
    .rst           (rst),
    .cap_stb       (cap_stb),
    .mode_code     (mode_code),
    .stereo_int_n  (stereo_int_n),
    .stereo_lamp_n (stereo_lamp_n),
    .stereo_rmt_n  (stereo_rmt_n),
    .mono_rmt_n    (mono_rmt_n),
    .single_ch_n   (single_ch_n),
    .eq_stereo_req (eq_stereo_req)
);

// File: tb/tb_audio_mode_decoder.sv
module tb_audio_mode_decoder;

    localparam int EQ_LANES = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cap_stb = 1'b0;
    logic [1:0]          mode_code = 2'b00;
    logic                stereo_int_n;
    logic                stereo_lamp_n;
    logic                stereo_rmt_n;
    logic                mono_rmt_n;
    logic                single_ch_n;
    logic [EQ_LANES-1:0] eq_stereo_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [6:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] model_code = 2'b00;

    always #5 clk = ~clk;

    audio_mode_decoder #(.EQ_LANES(EQ_LANES)) dut (
        .clk           (clk),
        .rst           (rst),
        .cap_stb       (cap_stb),
        .mode_code     (mode_code),
        .stereo_int_n  (stereo_int_n),
        .stereo_lamp_n (stereo_lamp_n),
        .stereo_rmt_n  (stereo_rmt_n),
        .mono_rmt_n    (mono_rmt_n),
        .single_ch_n   (single_ch_n),
        .eq_stereo_req (eq_stereo_req)
    );

    // Expected pattern {int_n, lamp_n, rmt_n, mono_n, single_n, eq[1:0]}
    function automatic logic [6:0] expect_for(input logic [1:0] code);
        logic st;
        logic one_side;
        st       = (code == 2'b00);
        one_side = (code == 2'b01) || (code == 2'b10);
        return {!st, !st, !st, st, !one_side, {EQ_LANES{st}}};
    endfunction

    task automatic step(input logic r, input logic s, input logic [1:0] c, input string tag);
        @(negedge clk);
        rst       = r;
        cap_stb   = s;
        mode_code = c;
        if (r) model_code = 2'b00;
        else if (s) model_code = c;
        exp_q.push_back(expect_for(model_code));
        tag_q.push_back(tag);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [6:0] e;
                logic [6:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {stereo_int_n, stereo_lamp_n, stereo_rmt_n, mono_rmt_n,
                     single_ch_n, eq_stereo_req};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: outputs %b expected %b", t, a, e);
                end
                checks++;
                if (!(stereo_rmt_n ^ mono_rmt_n)) begin
                    fails++;
                    $display("FAIL R8: remote pair %b%b expected one low", stereo_rmt_n, mono_rmt_n);
                end
                checks++;
                if (!(stereo_int_n == stereo_lamp_n && stereo_lamp_n == stereo_rmt_n
                      && eq_stereo_req == {EQ_LANES{!stereo_int_n}})) begin
                    fails++;
                    $display("FAIL R9: stereo group %b%b%b eq %b expected consistent",
                             stereo_int_n, stereo_lamp_n, stereo_rmt_n, eq_stereo_req);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver
    initial begin
        step(1'b1, 1'b0, 2'b11, "R1 reset");
        step(1'b1, 1'b0, 2'b11, "R1 reset hold");
        step(1'b0, 1'b0, 2'b01, "R3 no strobe after reset");
        step(1'b0, 1'b1, 2'b01, "R2 R5 mono left capture");
        step(1'b0, 1'b0, 2'b10, "R3 code change ignored");
        step(1'b0, 1'b0, 2'b11, "R3 code change ignored");
        step(1'b0, 1'b1, 2'b10, "R6 mono right capture");
        step(1'b0, 1'b1, 2'b11, "R7 mono sum capture");
        step(1'b0, 1'b0, 2'b01, "R3 hold mono sum");
        step(1'b0, 1'b1, 2'b00, "R4 stereo capture");
        step(1'b0, 1'b0, 2'b10, "R3 hold stereo");
        step(1'b0, 1'b1, 2'b11, "R7 stereo to mono sum");
        step(1'b0, 1'b1, 2'b01, "R5 mono sum to mono left");
        step(1'b0, 1'b1, 2'b10, "R6 mono left to mono right");
        step(1'b0, 1'b1, 2'b00, "R4 mono right to stereo");
        step(1'b0, 1'b1, 2'b10, "R6 stereo to mono right");
        step(1'b1, 1'b1, 2'b01, "R10 reset beats strobe");
        step(1'b0, 1'b0, 2'b01, "R3 hold after reset");
        step(1'b0, 1'b1, 2'b11, "R2 capture after reset");
        step(1'b0, 1'b0, 2'b11, "R2 settle");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule